// File: doc/BRIEF.md
# Reference Clock Failover Controller

This block watches two reference clocks against the feedback clock of a downstream PLL and decides which reference drives the PLL input mux. All three clocks are sampled in a faster system clock domain through synchronizers. A reference is judged faulty when the feedback clock keeps running but that reference stops producing rising edges. The fault is then held in a per-reference flag that stays set.

If the active reference is flagged and the other one is healthy, the block moves the selection to the healthy one on its own. It does this only while the manual-override input is low. With override high, the select input alone decides. An active-low alarm reset is reduced to one pulse however long it is held. That pulse clears both flags and puts the selection back on the select input. The PLL, the analog mux, the dividers and any bypass path sit outside this block.

Top module: `ref_failover_ctrl`

## Requirements
- R1: Selection value 0 means reference 0 and 1 means reference 1, on `sel_i`, `clk_sel_o` and `mux_sel_o` alike; `mux_sel_o` always equals `clk_sel_o`.
- R2: While `rst_ni` is low both bad flags are 0; on the first system-clock edge after release the selection loads `sel_i`.
- R3: A reference's bad flag sets when the feedback clock shows `MISS_EDGES` (default 4) synchronized rising edges with no rising edge of that reference between them; `MISS_EDGES`-1 such edges leave it clear.
- R4: A set bad flag stays high, even after its reference recovers, until an alarm-reset pulse.
- R5: A falling edge on `alarm_rst_ni`, after a two-stage synchronizer, clears both flags and loads the selection from `sel_i` at the third system-clock edge after the input falls.
- R6: Holding `alarm_rst_ni` low gives one clear event only; flags that set while it stays low remain set, and its return high has no effect.
- R7: With `man_ovr_i` low, if the active reference is flagged and the other is not, the selection toggles on the edge after the flag sets.
- R8: With both flags set and `man_ovr_i` low, the selection holds its value.
- R9: With `man_ovr_i` high, the selection takes `sel_i` on each edge and no automatic switch occurs.
- R10: A reference rising edge seen in the same cycle as a feedback rising edge counts as the reference being present and restarts its miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than all monitored clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref0_clk_i | input | 1 | Reference clock 0 (asynchronous) |
| ref1_clk_i | input | 1 | Reference clock 1 (asynchronous) |
| fb_clk_i | input | 1 | PLL feedback clock (asynchronous) |
| sel_i | input | 1 | Preferred reference (0 or 1) |
| man_ovr_i | input | 1 | 1 disables automatic switching |
| alarm_rst_ni | input | 1 | Active-low alarm reset, one-shotted |
| bad0_o | output | 1 | Sticky fault flag for reference 0 |
| bad1_o | output | 1 | Sticky fault flag for reference 1 |
| clk_sel_o | output | 1 | Reference in use (0 or 1) |
| mux_sel_o | output | 1 | Select to the downstream reference mux |

## Verification
The assertions check the cycle-level rules on every cycle. These are the equality of the two select outputs, flag stickiness between clear pulses, the effect of a clear pulse, the single width of that pulse, the toggle on a one-sided fault, the hold when both references are flagged, and override tracking. Only the bench's scenarios show the miss-count threshold itself. It runs N-1 against N missing reference edges, restarts the count on coincident edges, and shows that a held-low alarm reset does not clear faults that arrive afterwards. Loading the select input after reset also depends on a whole stimulus sequence.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned MISS_EDGES_DEF = 4;
  localparam int unsigned NUM_REFS       = 2;
  typedef logic [NUM_REFS-1:0] ref_vec_t;
endpackage

// File: rtl/rfc_sync_edge.sv
module rfc_sync_edge #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0,
  parameter bit          RISE    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], d_i};
      prev_q <= sr_q[MSB];
    end
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sr_q[MSB] & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sr_q[MSB] & prev_q;
    end
  endgenerate
endmodule

// File: rtl/rfc_loss_mon.sv
module rfc_loss_mon #(
  parameter int unsigned MISS_EDGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  input  logic clr_i,
  output logic bad_o
);
  localparam int unsigned CNT_W = $clog2(MISS_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_EDGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bad_q;
  logic             miss;

  // reference edge wins over a coincident feedback edge
  assign miss = fb_rise_i & ~ref_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (ref_rise_i) cnt_q <= '0;
      else if (miss && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      if (miss && cnt_q == LAST) bad_q <= 1'b1;
    end
  end

  assign bad_o = bad_q;
endmodule

// File: rtl/rfc_sel_ctrl.sv
module rfc_sel_ctrl
  import rfc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  logic     man_ovr_i,
  input  logic     clr_i,
  input  ref_vec_t bad_i,
  output logic     sel_o
);
  logic init_q;
  logic sel_q;
  logic act_bad, alt_bad;

  assign act_bad = bad_i[sel_q];
  assign alt_bad = bad_i[~sel_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      sel_q  <= 1'b0;
    end else begin
      init_q <= 1'b0;
      if (init_q || clr_i || man_ovr_i) sel_q <= sel_i;
      else if (act_bad && !alt_bad)     sel_q <= ~sel_q;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ref_failover_ctrl.sv
module ref_failover_ctrl
  import rfc_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  parameter int unsigned MISS_EDGES = MISS_EDGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref0_clk_i,
  input  logic ref1_clk_i,
  input  logic fb_clk_i,
  input  logic sel_i,
  input  logic man_ovr_i,
  input  logic alarm_rst_ni,
  output logic bad0_o,
  output logic bad1_o,
  output logic clk_sel_o,
  output logic mux_sel_o
);
  ref_vec_t ref_clk, ref_rise, bad;
  logic     fb_rise;
  logic     clr_pulse;
  logic     sel;

  assign ref_clk = {ref1_clk_i, ref0_clk_i};

  rfc_sync_edge #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0), .RISE(1'b1)) u_fb_sync (
    .clk_i, .rst_ni, .d_i(fb_clk_i), .edge_o(fb_rise)
  );

  // pulled-up input idles high; one pulse per falling edge
  rfc_sync_edge #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1), .RISE(1'b0)) u_alarm_os (
    .clk_i, .rst_ni, .d_i(alarm_rst_ni), .edge_o(clr_pulse)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    rfc_sync_edge #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0), .RISE(1'b1)) u_sync (
      .clk_i, .rst_ni, .d_i(ref_clk[i]), .edge_o(ref_rise[i])
    );
    rfc_loss_mon #(.MISS_EDGES(MISS_EDGES)) u_mon (
      .clk_i, .rst_ni, .ref_rise_i(ref_rise[i]), .fb_rise_i(fb_rise),
      .clr_i(clr_pulse), .bad_o(bad[i])
    );
  end

  rfc_sel_ctrl u_sel (
    .clk_i, .rst_ni, .sel_i, .man_ovr_i, .clr_i(clr_pulse), .bad_i(bad), .sel_o(sel)
  );

  assign bad0_o    = bad[0];
  assign bad1_o    = bad[1];
  assign clk_sel_o = sel;
  assign mux_sel_o = sel;
endmodule

// File: rtl/ref_failover_ctrl_chk.sv
module ref_failover_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic man_ovr_i,
  input logic bad0_o,
  input logic bad1_o,
  input logic clk_sel_o,
  input logic mux_sel_o,
  input logic clr_pulse
);
  logic armed_q;
  logic act_bad, alt_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign act_bad = clk_sel_o ? bad1_o : bad0_o;
  assign alt_bad = clk_sel_o ? bad0_o : bad1_o;

  p_mux_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_sel_o == clk_sel_o);

  p_sticky0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad0_o && !clr_pulse) |=> bad0_o);

  p_sticky1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad1_o && !clr_pulse) |=> bad1_o);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse |=> (!bad0_o && !bad1_o && clk_sel_o == $past(sel_i)));

  p_one_shot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pulse |=> !clr_pulse);

  p_auto_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !man_ovr_i && !clr_pulse && act_bad && !alt_bad)
      |=> clk_sel_o != $past(clk_sel_o));

  p_both_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !man_ovr_i && !clr_pulse && bad0_o && bad1_o) |=> $stable(clk_sel_o));

  p_override_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && man_ovr_i) |=> clk_sel_o == $past(sel_i));
endmodule

bind ref_failover_ctrl ref_failover_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .man_ovr_i(man_ovr_i),
  .bad0_o(bad0_o), .bad1_o(bad1_o), .clk_sel_o(clk_sel_o), .mux_sel_o(mux_sel_o),
  .clr_pulse(clr_pulse)
);

// File: tb/ref_failover_ctrl_tb_top.sv
module ref_failover_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref0 = 1'b0, ref1 = 1'b0, fb = 1'b0;
  logic sel = 1'b0, man = 1'b0, alarm_n = 1'b1;
  logic bad0, bad1, clk_sel, mux_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  b0;
    logic  b1;
    logic  s;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_failover_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref0_clk_i(ref0), .ref1_clk_i(ref1), .fb_clk_i(fb),
    .sel_i(sel), .man_ovr_i(man), .alarm_rst_ni(alarm_n),
    .bad0_o(bad0), .bad1_o(bad1), .clk_sel_o(clk_sel), .mux_sel_o(mux_sel)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bad0 !== e.b0 || bad1 !== e.b1 || clk_sel !== e.s || mux_sel !== e.s) begin
        errors++;
        $display("FAIL %s: got bad0=%b bad1=%b sel=%b mux=%b exp bad0=%b bad1=%b sel=%b",
                 e.tag, bad0, bad1, clk_sel, mux_sel, e.b0, e.b1, e.s);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input logic b0, input logic b1, input logic s, input string tag);
    exp_t e;
    e.b0 = b0; e.b1 = b1; e.s = s; e.tag = tag;
    exp_q.push_back(e);
    tick(1);
  endtask

  // one slow period: feedback always runs, references as requested
  task automatic period(input logic r0, input logic r1, input int n);
    for (int i = 0; i < n; i++) begin
      fb = 1'b1; ref0 = r0; ref1 = r1;
      tick(2);
      fb = 1'b0; ref0 = 1'b0; ref1 = 1'b0;
      tick(2);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running exp finished");
      finish_run();
    end
  end

  initial begin
    // R2: reset loads select input (1)
    sel = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_st(0, 0, 1, "R2 load sel=1 after reset");
    // R2 with select 0
    rst_n = 1'b0; sel = 1'b0;
    tick(2);
    expect_st(0, 0, 0, "R2 flags clear in reset");
    rst_n = 1'b1;
    tick(2);
    expect_st(0, 0, 0, "R1 R2 sel=0 chooses reference 0");

    // R10: coincident edges keep both healthy
    period(1, 1, 6);
    expect_st(0, 0, 0, "R10 coincident edges restart count");

    // R3: N-1 misses leave flag clear, N set it; R7 switch
    period(0, 1, 3);
    expect_st(0, 0, 0, "R3 three misses no flag");
    period(0, 1, 1);
    expect_st(1, 0, 1, "R3 R7 fourth miss flags and switches");

    // R4: sticky after recovery
    period(1, 1, 3);
    expect_st(1, 0, 1, "R4 flag sticky after recovery");

    // R8: both bad, selection holds
    period(1, 0, 4);
    expect_st(1, 1, 1, "R8 both flagged hold");
    period(0, 0, 3);
    expect_st(1, 1, 1, "R8 still holds");

    // R5: alarm clears and loads select
    alarm_n = 1'b0;
    tick(4);
    expect_st(0, 0, 0, "R5 alarm clears and loads sel");

    // R6: held low, new fault stays flagged
    period(0, 1, 4);
    expect_st(1, 0, 1, "R6 held alarm gives one event");
    alarm_n = 1'b1;
    tick(5);
    expect_st(1, 0, 1, "R6 release has no effect");

    // R9: override follows select, no auto switch
    man = 1'b1;
    tick(2);
    expect_st(1, 0, 0, "R9 override forces sel=0 despite flag");
    period(1, 1, 2);
    expect_st(1, 0, 0, "R9 no automatic switch");
    sel = 1'b1;
    tick(2);
    expect_st(1, 0, 1, "R9 override follows sel=1");
    sel = 1'b0;
    tick(2);
    expect_st(1, 0, 0, "R9 override follows sel=0");

    // R5 R7: clear with sel=1, then switch 1 -> 0
    man = 1'b0; sel = 1'b1;
    alarm_n = 1'b0;
    tick(4);
    alarm_n = 1'b1;
    expect_st(0, 0, 1, "R5 clear loads sel=1");
    period(1, 0, 4);
    expect_st(0, 1, 0, "R7 switch from reference 1 to 0");

    tick(3);
    done = 1'b1;
    finish_run();
  end
endmodule